// File: doc/BRIEF.md
# Per-Core Timer and Watchdog Window Decoder

This block sits between a processor-side register bus and an array of timer and watchdog register blocks, one timer and one watchdog for each of 1 to 4 cores. The address space is cut into consecutive 32-byte windows. The first two windows are "own core" windows. An access through either one reaches the timer or the watchdog of the core that issues it. The core is named by a core-ID input that is sampled together with the request. The windows after these reach every core's timer and watchdog at fixed addresses.

Each request is decoded in the cycle it is presented. The selected block receives a select strobe, a write enable, a word offset and write data in that same cycle. The response comes one cycle later, with the read data of the selected block or an error flag. Illegal accesses select nothing and return zero. The illegal cases are sub-word or oversized transfers, misaligned addresses, windows beyond the configured cores, and own-core accesses from a core ID that is not configured. The block also places the per-core timer and watchdog interrupts into one ordered vector. It drives a clear strobe that wipes the whole block array during reset.

Top module: `cpu_tmr_bank_dec`

## Requirements
- R1: The window index is address bits [8:5]. A window index w of 2 or more reaches block w-2. Block 2n is the timer of core n and block 2n+1 is its watchdog. Address bits [4:2] appear on `blk_off`, and exactly one block is selected for a legal access.
- R2: Window 0 reaches block 2·`req_core`, the timer of the requesting core.
- R3: Window 1 reaches block 2·`req_core`+1, the watchdog of the requesting core.
- R4: The `req_size` encoding is 0 = byte, 1 = halfword, 2 = word, 3 = doubleword. Only size 2 with address bits [1:0] equal to 0 is legal, and every other combination is an error.
- R5: An access to window 0 or 1 with `req_core` at or above NCORES is an error.
- R6: An access to a window index at or above 2+2·NCORES is an error.
- R7: An erroneous access sets `rsp_err`, returns `rsp_rdata` = 0 and raises no `blk_sel` bit and no `blk_we`, so no block is written.
- R8: Every request is answered by `rsp_valid` on the next cycle, with the selected block's read data at that offset. No request means no response.
- R9: Bit 2n of `irq_out` follows `tmr_irq[n]` and bit 2n+1 follows `wdg_irq[n]`.
- R10: `blk_clear` is high throughout reset and falls on the first clock after release. `rsp_valid` is low during reset.
- R11: Requests on consecutive cycles from different cores through the own-core windows are each routed by the core ID of their own cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address within the decoder's space |
| req_size | input | 2 | Transfer size code (see R4) |
| req_core | input | CID_W | ID of the requesting core |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_err | output | 1 | Response is an error |
| rsp_rdata | output | DATA_W | Read data, zero on error |
| blk_sel | output | 2·NCORES | One-hot block select |
| blk_we | output | 1 | Write enable for the selected block |
| blk_off | output | 3 | Word offset inside the block |
| blk_wdata | output | DATA_W | Write data to the blocks |
| blk_rdata | input | 2·NCORES·DATA_W | Read data of all blocks, block b at bits [b·DATA_W +: DATA_W] |
| blk_clear | output | 1 | Clears every block |
| tmr_irq | input | NCORES | Timer interrupt of each core |
| wdg_irq | input | NCORES | Watchdog interrupt of each core |
| irq_out | output | 2·NCORES | Ordered interrupt vector |

## Verification
The assertions check on every cycle that at most one block is selected, and that an erroneous access raises neither a select nor a write enable. They also check that narrow sizes and own-core accesses from unconfigured cores come back as errors, that error responses carry zero data, that every request gets exactly one response one cycle later, and that the clear strobe never returns after reset. Other behaviour can only be shown by the bench's scenarios with a model of the block array behind the decoder. These scenarios cover which block an own-core access actually lands in, that fixed and own-core windows reach the same storage, that rejected writes leave every block untouched, the interrupt ordering, and routing on back-to-back cycles from different cores.

// File: rtl/ctb_pkg.sv
package ctb_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_DWORD = 2'd3
  } acc_size_e;

  localparam int WIN_LSB    = 5;   // 32-byte windows
  localparam int OFF_LSB    = 2;   // word offset inside a window
  localparam int OFF_W      = 3;   // 8 words per window
  localparam int OWN_TMR    = 0;   // own-core timer window
  localparam int OWN_WDG    = 1;   // own-core watchdog window
  localparam int FIXED_BASE = 2;   // first fixed window

  // Flat block index: timer of core n is 2n, watchdog is 2n+1.
  function automatic int blk_of(input int core, input logic is_wdg);
    return 2 * core + int'(is_wdg);
  endfunction

endpackage

// File: rtl/ctb_win_decode.sv
module ctb_win_decode
  import ctb_pkg::*;
#(
  parameter int NCORES = 4,
  parameter int ADDR_W = 9,
  parameter int CID_W  = 2,
  parameter int BIDX_W = 3
) (
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [CID_W-1:0]  req_core,
  output logic              acc_hit,
  output logic              acc_err,
  output logic [BIDX_W-1:0] blk_idx,
  output logic [OFF_W-1:0]  reg_off
);

  localparam int WIN_W = ADDR_W - WIN_LSB;
  localparam int NWIN  = FIXED_BASE + 2 * NCORES;

  logic [WIN_W-1:0] win;
  logic             aligned;
  logic             is_word;
  logic             bad_tgt;
  int               tgt;

  always_comb begin
    win     = req_addr[ADDR_W-1:WIN_LSB];
    aligned = (req_addr[OFF_LSB-1:0] == '0);
    is_word = (req_size == SZ_WORD);
    reg_off = req_addr[WIN_LSB-1:OFF_LSB];
    if (int'(win) == OWN_TMR || int'(win) == OWN_WDG) begin
      bad_tgt = (int'(req_core) >= NCORES);
      tgt     = blk_of(int'(req_core), win[0]);
    end else begin
      bad_tgt = (int'(win) >= NWIN);
      tgt     = int'(win) - FIXED_BASE;
    end
    acc_err = req_valid && (!aligned || !is_word || bad_tgt);
    acc_hit = req_valid && !acc_err;
    blk_idx = bad_tgt ? '0 : BIDX_W'(tgt);
  end

endmodule

// File: rtl/ctb_route.sv
module ctb_route #(
  parameter int NBLK   = 8,
  parameter int DATA_W = 32,
  parameter int BIDX_W = 3,
  parameter int OFF_W  = 3
) (
  input  logic                   acc_hit,
  input  logic                   req_write,
  input  logic [BIDX_W-1:0]      blk_idx,
  input  logic [OFF_W-1:0]       reg_off,
  input  logic [DATA_W-1:0]      req_wdata,
  input  logic [NBLK*DATA_W-1:0] blk_rdata,
  output logic [NBLK-1:0]        blk_sel,
  output logic                   blk_we,
  output logic [OFF_W-1:0]       blk_off,
  output logic [DATA_W-1:0]      blk_wdata,
  output logic [DATA_W-1:0]      sel_rdata
);

  for (genvar b = 0; b < NBLK; b++) begin : g_sel
    assign blk_sel[b] = acc_hit && (blk_idx == BIDX_W'(b));
  end

  assign blk_we    = acc_hit && req_write;
  assign blk_off   = reg_off;
  assign blk_wdata = req_wdata;

  // AND-OR read mux; no select means zero.
  always_comb begin
    sel_rdata = '0;
    for (int b = 0; b < NBLK; b++) begin
      if (blk_sel[b]) sel_rdata = sel_rdata | blk_rdata[b*DATA_W +: DATA_W];
    end
  end

endmodule

// File: rtl/ctb_irq_order.sv
module ctb_irq_order #(
  parameter int NCORES = 4
) (
  input  logic [NCORES-1:0]   tmr_irq,
  input  logic [NCORES-1:0]   wdg_irq,
  output logic [2*NCORES-1:0] irq_out
);

  for (genvar n = 0; n < NCORES; n++) begin : g_core
    assign irq_out[2*n]   = tmr_irq[n];
    assign irq_out[2*n+1] = wdg_irq[n];
  end

endmodule

// File: rtl/cpu_tmr_bank_dec.sv
module cpu_tmr_bank_dec
  import ctb_pkg::*;
#(
  parameter int NCORES = 4,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 9,
  parameter int CID_W  = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  input  logic                       req_write,
  input  logic [ADDR_W-1:0]          req_addr,
  input  logic [1:0]                 req_size,
  input  logic [CID_W-1:0]           req_core,
  input  logic [DATA_W-1:0]          req_wdata,
  output logic                       rsp_valid,
  output logic                       rsp_err,
  output logic [DATA_W-1:0]          rsp_rdata,
  output logic [2*NCORES-1:0]        blk_sel,
  output logic                       blk_we,
  output logic [2:0]                 blk_off,
  output logic [DATA_W-1:0]          blk_wdata,
  input  logic [2*NCORES*DATA_W-1:0] blk_rdata,
  output logic                       blk_clear,
  input  logic [NCORES-1:0]          tmr_irq,
  input  logic [NCORES-1:0]          wdg_irq,
  output logic [2*NCORES-1:0]        irq_out
);

  localparam int NBLK   = 2 * NCORES;
  localparam int BIDX_W = (NBLK > 1) ? $clog2(NBLK) : 1;

  logic              acc_hit;
  logic              acc_err;
  logic [BIDX_W-1:0] blk_idx;
  logic [OFF_W-1:0]  reg_off;
  logic [DATA_W-1:0] sel_rdata;

  ctb_win_decode #(
    .NCORES(NCORES), .ADDR_W(ADDR_W), .CID_W(CID_W), .BIDX_W(BIDX_W)
  ) u_dec (
    .req_valid(req_valid), .req_addr(req_addr), .req_size(req_size),
    .req_core(req_core), .acc_hit(acc_hit), .acc_err(acc_err),
    .blk_idx(blk_idx), .reg_off(reg_off)
  );

  ctb_route #(
    .NBLK(NBLK), .DATA_W(DATA_W), .BIDX_W(BIDX_W), .OFF_W(OFF_W)
  ) u_route (
    .acc_hit(acc_hit), .req_write(req_write), .blk_idx(blk_idx),
    .reg_off(reg_off), .req_wdata(req_wdata), .blk_rdata(blk_rdata),
    .blk_sel(blk_sel), .blk_we(blk_we), .blk_off(blk_off),
    .blk_wdata(blk_wdata), .sel_rdata(sel_rdata)
  );

  ctb_irq_order #(.NCORES(NCORES)) u_irq (
    .tmr_irq(tmr_irq), .wdg_irq(wdg_irq), .irq_out(irq_out)
  );

  // Response and clear registers
  logic              rsp_valid_d, rsp_valid_q;
  logic              rsp_err_d,   rsp_err_q;
  logic [DATA_W-1:0] rsp_rdata_d, rsp_rdata_q;
  logic              rdata_en;
  logic              clear_d,     clear_q;

  always_comb begin
    rsp_valid_d = req_valid;
    rsp_err_d   = acc_err;
    rdata_en    = req_valid;
    rsp_rdata_d = acc_err ? '0 : sel_rdata;
    clear_d     = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_err_q   <= 1'b0;
      rsp_rdata_q <= '0;
      clear_q     <= 1'b1;
    end else begin
      rsp_valid_q <= rsp_valid_d;
      rsp_err_q   <= rsp_err_d;
      clear_q     <= clear_d;
      if (rdata_en) rsp_rdata_q <= rsp_rdata_d;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_err   = rsp_err_q;
  assign rsp_rdata = rsp_rdata_q;
  assign blk_clear = clear_q;

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(blk_sel)); // R1
  AST_ERR_NO_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err |-> (blk_sel == '0 && !blk_we)); // R7
  AST_NARROW_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_size != SZ_WORD) |=> rsp_err); // R4
  AST_OWN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_addr[ADDR_W-1:WIN_LSB+1] == '0 &&
     {1'b0, req_core} >= (CID_W+1)'(NCORES)) |=> rsp_err); // R5
  AST_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (rsp_rdata == '0)); // R7
  AST_RSP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R8
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid); // R8
  AST_CLEAR_GONE: assert property (@(posedge clk) disable iff (!rst_n)
    !blk_clear |=> !blk_clear); // R10

endmodule

// File: tb/cpu_tmr_bank_dec_test.sv
`timescale 1ns/1ps
module cpu_tmr_bank_dec_test;

  localparam int NC = 3;
  localparam int NB = 2 * NC;
  localparam int DW = 32;
  localparam int AW = 9;
  localparam int CW = 2;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              req_valid, req_write;
  logic [AW-1:0]     req_addr;
  logic [1:0]        req_size;
  logic [CW-1:0]     req_core;
  logic [DW-1:0]     req_wdata;
  logic              rsp_valid, rsp_err;
  logic [DW-1:0]     rsp_rdata;
  logic [NB-1:0]     blk_sel;
  logic              blk_we;
  logic [2:0]        blk_off;
  logic [DW-1:0]     blk_wdata;
  logic [NB*DW-1:0]  blk_rdata;
  logic              blk_clear;
  logic [NC-1:0]     tmr_irq, wdg_irq;
  logic [NB-1:0]     irq_out;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  cpu_tmr_bank_dec #(.NCORES(NC), .DATA_W(DW), .ADDR_W(AW), .CID_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_core(req_core),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
    .rsp_rdata(rsp_rdata), .blk_sel(blk_sel), .blk_we(blk_we),
    .blk_off(blk_off), .blk_wdata(blk_wdata), .blk_rdata(blk_rdata),
    .blk_clear(blk_clear), .tmr_irq(tmr_irq), .wdg_irq(wdg_irq),
    .irq_out(irq_out)
  );

  // Model of the block array behind the decoder
  logic [DW-1:0] regs [NB][8];
  always_ff @(posedge clk) begin
    if (blk_clear) begin
      for (int b = 0; b < NB; b++)
        for (int o = 0; o < 8; o++) regs[b][o] <= '0;
    end else begin
      for (int b = 0; b < NB; b++)
        if (blk_sel[b] && blk_we) regs[b][blk_off] <= blk_wdata;
    end
  end
  for (genvar b = 0; b < NB; b++) begin : g_rd
    assign blk_rdata[b*DW +: DW] = regs[b][blk_off];
  end

  function automatic logic [AW-1:0] wa(input int w, input int o);
    return AW'(w * 32 + o * 4);
  endfunction

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input bit wr, input logic [AW-1:0] a, input logic [1:0] sz,
                       input logic [CW-1:0] c, input logic [DW-1:0] d);
    req_valid = 1'b1; req_write = wr; req_addr = a;
    req_size = sz; req_core = c; req_wdata = d;
  endtask

  task automatic access(input bit wr, input logic [AW-1:0] a, input logic [1:0] sz,
                        input logic [CW-1:0] c, input logic [DW-1:0] d,
                        output logic v, output logic e, output logic [DW-1:0] rd);
    @(negedge clk);
    drive(wr, a, sz, c, d);
    @(negedge clk);
    req_valid = 1'b0;
    v = rsp_valid; e = rsp_err; rd = rsp_rdata;
  endtask

  task automatic t_reset();
    logic v, e; logic [DW-1:0] rd;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0;
    req_size = 2'd2; req_core = '0; req_wdata = '0; tmr_irq = '0; wdg_irq = '0;
    repeat (3) @(negedge clk);
    chk("R10 clear during reset", {31'b0, blk_clear}, 32'd1);
    chk("R10 no response in reset", {31'b0, rsp_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 clear falls after release", {31'b0, blk_clear}, 32'd0);
    for (int b = 0; b < NB; b++) begin
      access(0, wa(2 + b, 0), 2'd2, 0, 0, v, e, rd);
      chk("R10 block cleared", rd, 32'd0);
    end
  endtask

  task automatic t_fixed();
    logic v, e; logic [DW-1:0] rd;
    for (int b = 0; b < NB; b++) access(1, wa(2 + b, b), 2'd2, 0, 32'hA500_0000 | b, v, e, rd);
    for (int b = 0; b < NB; b++) begin
      access(0, wa(2 + b, b), 2'd2, 0, 0, v, e, rd);
      chk("R1 fixed window readback", rd, 32'hA500_0000 | b);
      chk("R8 response valid", {31'b0, v}, 32'd1);
      chk("R1 legal no error", {31'b0, e}, 32'd0);
      access(0, wa(2 + b, (b + 1) % 8), 2'd2, 0, 0, v, e, rd);
      chk("R1 neighbour offset untouched", rd, 32'd0);
    end
  endtask

  task automatic t_own_tmr();
    logic v, e; logic [DW-1:0] rd;
    access(1, wa(0, 3), 2'd2, 1, 32'h1111_0003, v, e, rd);
    access(0, wa(2 + 2, 3), 2'd2, 0, 0, v, e, rd);
    chk("R2 own timer lands in core 1 timer", rd, 32'h1111_0003);
    access(0, wa(2 + 0, 3), 2'd2, 0, 0, v, e, rd);
    chk("R2 core 0 timer untouched", rd, 32'd0);
  endtask

  task automatic t_own_wdg();
    logic v, e; logic [DW-1:0] rd;
    access(1, wa(1, 6), 2'd2, 2, 32'h2222_0006, v, e, rd);
    access(0, wa(2 + 5, 6), 2'd2, 0, 0, v, e, rd);
    chk("R3 own watchdog lands in core 2 watchdog", rd, 32'h2222_0006);
    access(0, wa(2 + 4, 6), 2'd2, 0, 0, v, e, rd);
    chk("R3 core 2 timer untouched", rd, 32'd0);
    access(0, wa(1, 6), 2'd2, 2, 0, v, e, rd);
    chk("R3 own watchdog readback", rd, 32'h2222_0006);
  endtask

  task automatic t_size();
    logic v, e; logic [DW-1:0] rd;
    for (int s = 0; s < 4; s++) begin
      if (s == 2) continue;
      access(1, wa(2, 0), 2'(s), 0, 32'hDEAD_0000, v, e, rd);
      chk("R4 bad size rejected", {31'b0, e}, 32'd1);
    end
    access(1, wa(2, 0) + 1, 2'd2, 0, 32'hDEAD_0001, v, e, rd);
    chk("R4 misaligned rejected", {31'b0, e}, 32'd1);
    access(1, wa(2, 0) + 2, 2'd2, 0, 32'hDEAD_0002, v, e, rd);
    chk("R4 misaligned by two rejected", {31'b0, e}, 32'd1);
    access(0, wa(2, 0), 2'd0, 0, 0, v, e, rd);
    chk("R7 error read returns zero", rd, 32'd0);
    access(0, wa(2, 0), 2'd2, 0, 0, v, e, rd);
    chk("R7 rejected writes left block intact", rd, 32'hA500_0000);
  endtask

  task automatic t_own_range();
    logic v, e; logic [DW-1:0] rd;
    access(1, wa(0, 7), 2'd2, 3, 32'hBAD0_0007, v, e, rd);
    chk("R5 own timer from core 3 rejected", {31'b0, e}, 32'd1);
    access(0, wa(1, 7), 2'd2, 3, 0, v, e, rd);
    chk("R5 own watchdog from core 3 rejected", {31'b0, e}, 32'd1);
    chk("R7 rejected read data zero", rd, 32'd0);
    for (int b = 0; b < NB; b++) begin
      access(0, wa(2 + b, 7), 2'd2, 0, 0, v, e, rd);
      chk("R7 no block written", rd, 32'd0);
    end
  endtask

  task automatic t_win_range();
    logic v, e; logic [DW-1:0] rd;
    access(1, wa(2 + NB, 0), 2'd2, 0, 32'hBAD0_0008, v, e, rd);
    chk("R6 first missing window rejected", {31'b0, e}, 32'd1);
    access(0, wa(15, 0), 2'd2, 0, 0, v, e, rd);
    chk("R6 last window rejected", {31'b0, e}, 32'd1);
    access(0, wa(2 + NB - 1, 0), 2'd2, 0, 0, v, e, rd);
    chk("R6 last real window legal", {31'b0, e}, 32'd0);
    access(0, wa(2, 0), 2'd2, 0, 0, v, e, rd);
    chk("R7 window-miss write had no effect", rd, 32'hA500_0000);
  endtask

  task automatic t_irq();
    logic [NC-1:0] tp [3] = '{3'b101, 3'b010, 3'b111};
    logic [NC-1:0] wp [3] = '{3'b010, 3'b001, 3'b100};
    for (int p = 0; p < 3; p++) begin
      logic [NB-1:0] exp;
      tmr_irq = tp[p]; wdg_irq = wp[p];
      for (int n = 0; n < NC; n++) begin
        exp[2*n]   = tp[p][n];
        exp[2*n+1] = wp[p][n];
      end
      #1;
      chk("R9 interrupt order", 32'(irq_out), 32'(exp));
    end
    tmr_irq = '0; wdg_irq = '0;
  endtask

  task automatic t_b2b();
    @(negedge clk);
    drive(0, wa(0, 3), 2'd2, 1, 0);
    @(negedge clk);
    chk("R11 first of burst core 1", rsp_rdata, 32'h1111_0003);
    drive(0, wa(0, 0), 2'd2, 0, 0);
    @(negedge clk);
    chk("R11 second of burst core 0", rsp_rdata, 32'hA500_0000);
    drive(0, wa(1, 6), 2'd2, 2, 0);
    @(negedge clk);
    chk("R11 third of burst core 2", rsp_rdata, 32'h2222_0006);
    req_valid = 1'b0;
    @(negedge clk);
    chk("R8 idle gives no response", {31'b0, rsp_valid}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_fixed();
    t_own_tmr();
    t_own_wdg();
    t_size();
    t_own_range();
    t_win_range();
    t_irq();
    t_b2b();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule